// File: doc/BRIEF.md
# Calibrated Watch Timebase Divider

This block turns a 32.768 kHz oscillator clock into the slow timing events of a quartz watch: a one-second motor tick, a 32 Hz tick, a one-minute strobe and a four-minute housekeeping strobe. It also produces a square wave at a thirty-second of a second, which can be used to measure the oscillator. Crystals that run fast are trimmed digitally. At each calibration boundary, a programmable number N (0 to 127) of pulses at the 8192 Hz stage is dropped. The one-second chain then stalls for N × 4 oscillator cycles. The boundary falls once a minute or once every two minutes, depending on a select bit.

The chain is a prescaler by four to the 8192 Hz stage, followed by modulo stages to 32 Hz, 8 Hz and 1 Hz, then a seconds counter and a minute counter. A down-counter between the prescaler and the rest of the chain absorbs the deleted pulses. The deletions occur on consecutive 8192 Hz pulses right after the boundary, so no second is ever lost or counted twice.

An inhibit-measurement mode reloads the deletion at every 32 Hz period, so the square-wave period directly shows N. An accelerated mode makes the housekeeping strobe fire every second. Configuration arrives as plain static inputs. All sizes are parameters; the defaults give the real-time ratios.

Top module: `tbd_calib_divider`

## Requirements
- R1: With N = 0, tick_1hz pulses every CPS = PRE_DIV·SUB32_DIV·SUB8_DIV·SUB1_DIV cycles (32768 by default), and tick_32hz pulses every PRE_DIV·SUB32_DIV cycles (1024 by default).
- R2: N is read from swallow_cnt as an unsigned value with bit 6 as the MSB (weight 64). After every calibration boundary, the next N prescaler pulses are deleted. The second that follows is exactly PRE_DIV·N cycles longer, and every other second keeps its length.
- R3: With period_2min = 0, a calibration boundary ends every minute. With period_2min = 1, a boundary ends every second minute, starting with the second minute after reset. Every fourth minute's end, including the one carrying strobe_4min, is then a boundary.
- R4: tick_1hz is a single-cycle pulse. For any N, exactly SEC_PER_MIN ticks fall between consecutive minute strobes, counting the tick that coincides with the closing strobe.
- R5: strobe_min pulses once every SEC_PER_MIN seconds, in the same cycle as tick_1hz.
- R6: In modes 2'b00 and 2'b01, strobe_4min pulses at the end of every MIN_PER_HK-th minute, in the same cycle as strobe_min and tick_1hz.
- R7: In run mode (meas_mode = 2'b00), test_out is high during the upper half of the 32 Hz stage. Its period is PRE_DIV·SUB32_DIV cycles when N = 0.
- R8: With meas_mode = 2'b01 (inhibit measurement), the deletion is reloaded at every wrap of the 32 Hz stage instead of at calibration boundaries. The period of test_out becomes PRE_DIV·SUB32_DIV + PRE_DIV·N cycles, which is 31.25 ms + N·0.122 ms by default.
- R9: A low rst_n asynchronously clears every stage, the deletion counter and all outputs. After release, counting restarts on the third rising edge, so the first tick_1hz is high in cycle CPS+2 after release. A deletion that was pending before the reset is dropped.
- R10: When meas_mode[1] = 1 (codes 2'b10 and 2'b11), strobe_4min pulses together with every tick_1hz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock, 32.768 kHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| swallow_cnt | input | 7 | Number N of prescaler pulses deleted per calibration period |
| period_2min | input | 1 | Calibration period select: 0 = one minute, 1 = two minutes |
| meas_mode | input | 2 | 00 run, 01 inhibit measurement, 1x accelerated housekeeping |
| tick_1hz | output | 1 | One-cycle pulse per second |
| tick_32hz | output | 1 | One-cycle pulse per 32 Hz period |
| strobe_min | output | 1 | One-cycle pulse per minute |
| strobe_4min | output | 1 | One-cycle housekeeping pulse (every fourth minute, or every second) |
| test_out | output | 1 | 32 Hz square wave; stretched by N in inhibit mode |

## Verification
Two events can land in the same cycle. The first is the reload of the deletion counter at a calibration boundary. The second is the housekeeping strobe, which closes the fourth minute, and with the two-minute period every such closing is also a boundary. The bench runs with period_2min = 1 and N = 9 and stops on a housekeeping strobe. It checks that strobe_min and tick_1hz are high in that same cycle, and that the very next minute is stretched by 36 cycles. In accelerated mode, the housekeeping strobe also falls on the second that starts a deletion; that second must be stretched while the strobe keeps its one-per-tick pattern.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

  // Measurement-mode codes; bit 1 selects accelerated housekeeping
  typedef enum logic [1:0] {
    TBD_RUN      = 2'b00,
    TBD_INHIBIT  = 2'b01,
    TBD_FAST     = 2'b10,
    TBD_FAST_ALT = 2'b11
  } tbd_mode_e;

  function automatic logic mode_is_fast(tbd_mode_e m);
    return (m == TBD_FAST) || (m == TBD_FAST_ALT);
  endfunction

endpackage

// File: rtl/tbd_rst_sync.sv
module tbd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/tbd_mod_counter.sv
module tbd_mod_counter #(
  parameter int MODULUS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  output logic [$clog2(MODULUS)-1:0] q,
  output logic                       wrap
);

  localparam int W = $clog2(MODULUS);
  localparam bit IS_POW2 = ((MODULUS & (MODULUS - 1)) == 0);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_last;

  assign at_last = (cnt_q == W'(MODULUS - 1));
  assign wrap    = en && at_last;
  assign q       = cnt_q;

  generate
    if (IS_POW2) begin : g_pow2
      // natural rollover of a binary counter
      always_comb begin
        cnt_d = cnt_q;
        if (en) cnt_d = cnt_q + W'(1);
      end
    end else begin : g_mod
      always_comb begin
        cnt_d = cnt_q;
        if (en) cnt_d = at_last ? '0 : cnt_q + W'(1);
      end

      // R4: a stage never leaves its legal range, so no tick is skipped
      assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(MODULUS - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tbd_swallow_ctl.sv
module tbd_swallow_ctl #(
  parameter int N_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pulse_8k,
  input  logic           load,
  input  logic [N_W-1:0] load_val,
  output logic           adv_8k,
  output logic           busy
);

  logic [N_W-1:0] left_q;
  logic [N_W-1:0] left_d;

  assign busy   = (left_q != '0);
  assign adv_8k = pulse_8k && !busy;

  always_comb begin
    left_d = left_q;
    if (load)                  left_d = load_val;
    else if (pulse_8k && busy) left_d = left_q - N_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  // R2: a reload only arrives once the previous deletion run is finished
  assert_load_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (left_q == '0));

  // R2: each prescaler pulse taken while busy removes exactly one pulse
  assert_dec_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pulse_8k) |=> (left_q == $past(left_q) - N_W'(1)));

endmodule

// File: rtl/tbd_calib_divider.sv
module tbd_calib_divider #(
  parameter int PRE_DIV     = 4,
  parameter int SUB32_DIV   = 256,
  parameter int SUB8_DIV    = 4,
  parameter int SUB1_DIV    = 8,
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_HK  = 4,
  parameter int N_W         = 7
) (
  input  logic           clk_osc,
  input  logic           rst_n,
  input  logic [N_W-1:0] swallow_cnt,
  input  logic           period_2min,
  input  logic [1:0]     meas_mode,
  output logic           tick_1hz,
  output logic           tick_32hz,
  output logic           strobe_min,
  output logic           strobe_4min,
  output logic           test_out
);

  import tbd_pkg::*;

  localparam int W_PRE = $clog2(PRE_DIV);
  localparam int W_32  = $clog2(SUB32_DIV);
  localparam int W_8   = $clog2(SUB8_DIV);
  localparam int W_1   = $clog2(SUB1_DIV);
  localparam int W_SEC = $clog2(SEC_PER_MIN);
  localparam int W_HK  = $clog2(MIN_PER_HK);

  logic rst_sync_n;

  tbd_rst_sync u_rst (
    .clk        (clk_osc),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // ---------------- chain ----------------
  logic             pre_wrap, adv_8k, swl_busy;
  logic             w32, w8, w1, wmin, whk, wpar;
  logic [W_32-1:0]  mid_q;
  logic [0:0]       par_q;
  logic [W_PRE-1:0] unused_pre_q;
  logic [W_8-1:0]   unused_q8;
  logic [W_1-1:0]   unused_q1;
  logic [W_SEC-1:0] unused_sec_q;
  logic [W_HK-1:0]  unused_hk_q;
  logic             unused_par_wrap;

  tbd_mod_counter #(.MODULUS(PRE_DIV)) u_pre (
    .clk (clk_osc), .rst_n (rst_sync_n), .en (1'b1),
    .q (unused_pre_q), .wrap (pre_wrap)
  );

  logic load_swl;

  tbd_swallow_ctl #(.N_W(N_W)) u_swl (
    .clk      (clk_osc),
    .rst_n    (rst_sync_n),
    .pulse_8k (pre_wrap),
    .load     (load_swl),
    .load_val (swallow_cnt),
    .adv_8k   (adv_8k),
    .busy     (swl_busy)
  );

  tbd_mod_counter #(.MODULUS(SUB32_DIV)) u_c32 (
    .clk (clk_osc), .rst_n (rst_sync_n), .en (adv_8k),
    .q (mid_q), .wrap (w32)
  );

  tbd_mod_counter #(.MODULUS(SUB8_DIV)) u_c8 (
    .clk (clk_osc), .rst_n (rst_sync_n), .en (w32),
    .q (unused_q8), .wrap (w8)
  );

  tbd_mod_counter #(.MODULUS(SUB1_DIV)) u_c1 (
    .clk (clk_osc), .rst_n (rst_sync_n), .en (w8),
    .q (unused_q1), .wrap (w1)
  );

  tbd_mod_counter #(.MODULUS(SEC_PER_MIN)) u_sec (
    .clk (clk_osc), .rst_n (rst_sync_n), .en (w1),
    .q (unused_sec_q), .wrap (wmin)
  );

  tbd_mod_counter #(.MODULUS(MIN_PER_HK)) u_hk (
    .clk (clk_osc), .rst_n (rst_sync_n), .en (wmin),
    .q (unused_hk_q), .wrap (whk)
  );

  // minute parity: odd minutes close a two-minute calibration period
  tbd_mod_counter #(.MODULUS(2)) u_par (
    .clk (clk_osc), .rst_n (rst_sync_n), .en (wmin),
    .q (par_q), .wrap (unused_par_wrap)
  );
  assign wpar = par_q[0];

  // ---------------- mode decode and reload ----------------
  tbd_mode_e mode_w;
  logic      inhibit_w, fast_w, cal_edge;

  assign mode_w    = tbd_mode_e'(meas_mode);
  assign inhibit_w = (mode_w == TBD_INHIBIT);
  assign fast_w    = mode_is_fast(mode_w);
  assign cal_edge  = wmin && (!period_2min || wpar);
  assign load_swl  = inhibit_w ? w32 : cal_edge;

  // ---------------- output registers ----------------
  logic tick1_d, tick32_d, smin_d, shk_d;

  always_comb begin
    tick1_d  = w1;
    tick32_d = w32;
    smin_d   = wmin;
    shk_d    = fast_w ? w1 : whk;
  end

  always_ff @(posedge clk_osc or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tick_1hz    <= 1'b0;
      tick_32hz   <= 1'b0;
      strobe_min  <= 1'b0;
      strobe_4min <= 1'b0;
    end else begin
      tick_1hz    <= tick1_d;
      tick_32hz   <= tick32_d;
      strobe_min  <= smin_d;
      strobe_4min <= shk_d;
    end
  end

  assign test_out = mid_q[W_32-1];

  // ---------------- assertions ----------------
  // R2: while pulses are being deleted the 32 Hz stage stands still
  assert_hold_swallow_R2: assert property (@(posedge clk_osc) disable iff (!rst_sync_n)
    swl_busy |=> $stable(mid_q));

  // R4: the second tick is one cycle wide
  assert_tick_single_R4: assert property (@(posedge clk_osc) disable iff (!rst_sync_n)
    tick_1hz |=> !tick_1hz);

  // R5: minute strobe always lands on a second tick
  assert_min_on_tick_R5: assert property (@(posedge clk_osc) disable iff (!rst_sync_n)
    strobe_min |-> tick_1hz);

  // R6: housekeeping strobe always lands on a second tick
  assert_hk_on_tick_R6: assert property (@(posedge clk_osc) disable iff (!rst_sync_n)
    strobe_4min |-> tick_1hz);

  // R6: outside accelerated mode the housekeeping strobe closes a minute
  assert_hk_on_min_R6: assert property (@(posedge clk_osc) disable iff (!rst_sync_n)
    (strobe_4min && !$past(meas_mode[1])) |-> strobe_min);

endmodule

// File: tb/tbd_calib_divider_tb_top.sv
module tbd_calib_divider_tb_top;

  localparam int PRE  = 4;
  localparam int S32  = 8;
  localparam int S8   = 4;
  localparam int S1   = 8;
  localparam int SPM  = 2;
  localparam int MHK  = 4;
  localparam int CPS  = PRE * S32 * S8 * S1;   // 1024
  localparam int P32  = PRE * S32;             // 32
  localparam int MINC = CPS * SPM;             // 2048

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] swallow_cnt;
  logic       period_2min;
  logic [1:0] meas_mode;
  logic       tick_1hz, tick_32hz, strobe_min, strobe_4min, test_out;

  always #4 clk = ~clk;  // 125 MHz

  tbd_calib_divider #(
    .PRE_DIV(PRE), .SUB32_DIV(S32), .SUB8_DIV(S8), .SUB1_DIV(S1),
    .SEC_PER_MIN(SPM), .MIN_PER_HK(MHK), .N_W(7)
  ) dut_i (
    .clk_osc(clk), .rst_n(rst_n), .swallow_cnt(swallow_cnt),
    .period_2min(period_2min), .meas_mode(meas_mode),
    .tick_1hz(tick_1hz), .tick_32hz(tick_32hz), .strobe_min(strobe_min),
    .strobe_4min(strobe_4min), .test_out(test_out)
  );

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  reported = 1'b0;

  typedef struct packed {
    logic [1:0]  mode;
    logic        sel;
    logic [6:0]  n;
    logic [2:0]  kind;   // 0 minute strobe, 1 test_out rise, 2 housekeeping strobe
    logic [15:0] exp_a;
    logic [15:0] exp_b;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 1'b0, 7'd0,   3'd0, 16'd2048, 16'd2048},
    '{2'b00, 1'b0, 7'd1,   3'd0, 16'd2052, 16'd2052},
    '{2'b00, 1'b0, 7'd127, 3'd0, 16'd2556, 16'd2556},
    '{2'b00, 1'b0, 7'd64,  3'd0, 16'd2304, 16'd2304},
    '{2'b00, 1'b1, 7'd5,   3'd0, 16'd2048, 16'd2068},
    '{2'b00, 1'b1, 7'd127, 3'd0, 16'd2048, 16'd2556},
    '{2'b01, 1'b0, 7'd0,   3'd1, 16'd32,   16'd32},
    '{2'b01, 1'b0, 7'd3,   3'd1, 16'd44,   16'd44},
    '{2'b01, 1'b1, 7'd127, 3'd1, 16'd540,  16'd540},
    '{2'b10, 1'b0, 7'd10,  3'd2, 16'd1024, 16'd1064}
  };

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // counts falling edges until the chosen event is seen
  task automatic wait_evt(input int kind, output int n);
    logic prev, hit;
    n = 0;
    prev = test_out;
    hit = 1'b0;
    while (!hit && n < 20000) begin
      @(negedge clk);
      n++;
      case (kind)
        0: hit = strobe_min;
        1: hit = test_out && !prev;
        2: hit = strobe_4min;
        3: hit = tick_1hz;
        default: hit = tick_32hz;
      endcase
      prev = test_out;
    end
  endtask

  function automatic string vec_tag(vec_t v);
    if (v.kind == 3'd1) return "R8";
    if (v.kind == 3'd2) return "R10";
    if (v.sel)          return "R3";
    return "R2";
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    int d, a, b, ticks;
    rst_n = 1'b0;
    swallow_cnt = 7'd0;
    period_2min = 1'b0;
    meas_mode = 2'b00;
    repeat (3) @(negedge clk);

    // R9: outputs quiet while reset is held
    check("R9 reset outputs", int'({tick_1hz, tick_32hz, strobe_min, strobe_4min, test_out}), 0);
    rst_n = 1'b1;
    // R9 / R1: first tick lands CPS+2 cycles after release
    wait_evt(3, d);
    check("R9 first tick", d, CPS + 2);
    // R1: steady second and 32 Hz spacing with N = 0
    for (int i = 0; i < 3; i++) begin
      wait_evt(3, d);
      check("R1 tick_1hz interval", d, CPS);
    end
    wait_evt(4, d);
    wait_evt(4, d);
    check("R1 tick_32hz interval", d, P32);
    // R7: run-mode square wave period
    wait_evt(1, d);
    wait_evt(1, d);
    check("R7 test_out period", d, P32);

    // table of configurations walked by one loop
    for (int i = 0; i < NVEC; i++) begin
      meas_mode   = VECS[i].mode;
      period_2min = VECS[i].sel;
      swallow_cnt = VECS[i].n;
      do_reset();
      wait_evt(int'(VECS[i].kind), d);
      wait_evt(int'(VECS[i].kind), a);
      wait_evt(int'(VECS[i].kind), b);
      check({vec_tag(VECS[i]), " interval a"}, a, int'(VECS[i].exp_a));
      check({vec_tag(VECS[i]), " interval b"}, b, int'(VECS[i].exp_b));
    end

    // R4 / R2: stretched second alternates with normal ones, one tick each
    meas_mode = 2'b00; period_2min = 1'b0; swallow_cnt = 7'd20;
    do_reset();
    wait_evt(3, d);
    wait_evt(3, a); check("R4 tick interval sec1", a, CPS);
    wait_evt(3, a); check("R2 tick interval stretched", a, CPS + 80);
    wait_evt(3, a); check("R4 tick interval sec3", a, CPS);
    wait_evt(3, a); check("R2 tick interval stretched 2", a, CPS + 80);
    // R4 / R5: exactly SPM ticks per minute, last one with the strobe
    wait_evt(0, d);
    ticks = 0;
    d = 0;
    do begin
      @(negedge clk);
      d++;
      if (tick_1hz) ticks++;
    end while (!strobe_min && d < 20000);
    check("R4 ticks per minute", ticks, SPM);
    check("R5 strobe with tick", int'(tick_1hz), 1);

    // R6 / R3: housekeeping strobe and calibration reload in one cycle
    period_2min = 1'b1; swallow_cnt = 7'd9;
    do_reset();
    wait_evt(2, d);
    check("R6 hk with minute strobe", int'(strobe_min), 1);
    check("R6 hk with tick", int'(tick_1hz), 1);
    wait_evt(0, a);
    check("R3 minute after hk stretched", a, MINC + 36);
    wait_evt(2, b);
    check("R6 hk remaining interval", b, MHK * MINC + 72 - (MINC + 36));

    // R9: reset during a pending deletion drops it
    period_2min = 1'b0; swallow_cnt = 7'd50;
    do_reset();
    wait_evt(0, d);
    do_reset();
    wait_evt(3, d);
    check("R9 first tick after mid-run reset", d, CPS + 2);

    // R10: code 2'b11 also gives a housekeeping strobe every second
    meas_mode = 2'b11; swallow_cnt = 7'd0;
    do_reset();
    wait_evt(2, d);
    wait_evt(2, a);
    check("R10 alt code hk interval", a, CPS);

    report();
  end

endmodule